// File: doc/BRIEF.md
# Upper-Memory Shadow Region Decoder

This block sits in the memory path of a 386/486-class system controller. It watches every memory access in the 256 KB window from C0000h to FFFFFh and picks where the access goes: the AT expansion bus, where option and system ROMs live, or the local DRAM that holds a shadow copy of them. For each access it also raises a write-suppress flag when shadow DRAM is write-protected, and it reports whether the first-level and second-level caches may hold the data. Accesses outside the window pass through as ordinary cacheable DRAM cycles.

Firmware sets up the decoder through an index/data pair of I/O ports. A write to the index port selects a configuration byte and arms the port pair. The next data-port access reads or writes that byte, and then the pair disarms. The index logic is a two-state machine. `IDX_IDLE` moves to `IDX_ARMED` on an index write. `IDX_ARMED` stays armed on a further index write and returns to `IDX_IDLE` on any data-port read or write. Shadow enables work on 16 KB segments, while write protection and L1 cacheability work on whole 64 KB ranges. Copy modes let the ROM be read from the bus while its image is written into DRAM.

Top module: `umem_shadow_decoder`

## Requirements
- R1: A write to I/O port 0022h latches the index and arms the pair. The next access to port 0024h writes (io_wr) or returns on io_rdata (io_rd) the selected byte, and that access disarms the pair. A later data read returns FFh.
- R2: A data-port write while disarmed, or to an index outside 30h..36h, changes no register. A read in those cases returns FFh.
- R3: After reset, all bytes read 00h except 31h and 32h, which read 20h.
- R4: A strobed access with address bits [ADDR_W-1:18] not equal to 3 (outside C0000h..FFFFFh) selects DRAM, sets both cacheable flags and never inhibits.
- R5: Register map. 30h/31h/32h serve the C/D/E 64 KB ranges. Bit n of each enables 16 KB segment n (address bits [15:14]), bit 4 is the range's read-only bit, and bit 5 is the copy bit for C and the whole-range enable for D and E. A C segment is shadowed when its bit is set. A D or E segment is shadowed when both its bit and the whole-range enable are set. Shadowed reads and writes select DRAM.
- R6: An unshadowed C/D/E segment sends reads and writes to the AT bus, with both cacheable flags clear and no inhibit.
- R7: A write to shadowed DRAM (no copy mode) in a range whose read-only bit is set selects DRAM and asserts wr_inhibit. Reads are unaffected.
- R8: The F000 range (register 33h: bit 0 read-only, bit 1 copy) is always shadowed. With copy clear, reads and writes select DRAM, both cacheable flags are set, and writes are inhibited when bit 0 is set.
- R9: With F copy set, F reads select the AT bus and F writes select DRAM, with no inhibit and both cacheable flags clear.
- R10: With the C copy bit set, a shadowed C segment sends reads to the AT bus and writes to DRAM, with no inhibit and no cacheability.
- R11: A shadowed C/D/E access in non-copy mode reports cache_l2 from bit (address bits [17:14]) of {35h[3:0], 34h}, and cache_l1 from 36h bit 0/1/2 for C/D/E.
- R12: With neither strobe active, all five outputs are 0. At most one select is ever high. When both strobes are high, the access is decoded as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | IO_W | I/O port address |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | Selected configuration byte, or FFh |
| mem_addr | input | ADDR_W | Memory byte address |
| mem_rd | input | 1 | Memory read strobe |
| mem_wr | input | 1 | Memory write strobe |
| sel_at | output | 1 | Access goes to the AT bus |
| sel_dram | output | 1 | Access goes to local DRAM |
| wr_inhibit | output | 1 | Suppress the DRAM write |
| cache_l1 | output | 1 | Data may be cached in L1 |
| cache_l2 | output | 1 | Data may be cached in L2 |

## Verification
Every 16 KB segment of the window, together with addresses just below C0000h, at 100000h and with high address bits set, is swept with reads, writes, combined strobes and idle cycles. This is repeated under dozens of pseudo-random register images, so that segment enables, whole-range enables, read-only bits, copy bits and cacheable bits appear in many combinations. Each access class (outside, unshadowed, shadowed read, protected write, C copy, F copy) is scored separately, so a fault in one policy branch cannot hide behind another. Directed port sequences separate the armed and disarmed index states, unmapped indices and reset values.

// File: rtl/umem_pkg.sv
package umem_pkg;

    typedef enum logic [1:0] {
        RNG_C = 2'd0,
        RNG_D = 2'd1,
        RNG_E = 2'd2,
        RNG_F = 2'd3
    } rng_e;

    typedef enum logic {
        IDX_IDLE  = 1'b0,
        IDX_ARMED = 1'b1
    } idx_state_e;

    localparam int NUM_REGS = 7;
    localparam int R_CSEG   = 0;
    localparam int R_DSEG   = 1;
    localparam int R_ESEG   = 2;
    localparam int R_FCTL   = 3;
    localparam int R_L2LO   = 4;
    localparam int R_L2HI   = 5;
    localparam int R_L1     = 6;

    typedef struct packed {
        logic [3:0]  c_seg;
        logic [3:0]  d_seg;
        logic [3:0]  e_seg;
        logic        c_ro;
        logic        d_ro;
        logic        e_ro;
        logic        f_ro;
        logic        c_copy;
        logic        f_copy;
        logic        d_all;
        logic        e_all;
        logic [11:0] l2;
        logic [2:0]  l1;
    } shadow_cfg_t;

    typedef struct packed {
        logic sel_at;
        logic sel_dram;
        logic wr_inh;
        logic l1;
        logic l2;
    } route_t;

    function automatic logic [7:0] reg_reset(input int idx);
        return (idx == R_DSEG || idx == R_ESEG) ? 8'h20 : 8'h00;
    endfunction

endpackage

// File: rtl/umem_cfg_regs.sv
module umem_cfg_regs
    import umem_pkg::*;
#(
    parameter int          IO_W     = 16,
    parameter logic [15:0] IDX_PORT = 16'h0022,
    parameter logic [15:0] DAT_PORT = 16'h0024,
    parameter logic [7:0]  REG_BASE = 8'h30
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IO_W-1:0] io_addr,
    input  logic            io_wr,
    input  logic            io_rd,
    input  logic [7:0]      io_wdata,
    output logic [7:0]      io_rdata,
    output shadow_cfg_t     cfg,
    output logic            armed
);

    localparam logic [IO_W-1:0] IDX_A = IO_W'(IDX_PORT);
    localparam logic [IO_W-1:0] DAT_A = IO_W'(DAT_PORT);

    idx_state_e state_q, state_d;
    logic [7:0] idx_q;
    logic [7:0] idx_off;
    logic       idx_hit;
    logic       idx_wr;
    logic       dat_acc;
    logic       dat_wr_hit;
    logic [7:0] regs_q [NUM_REGS];

    assign idx_wr     = io_wr && (io_addr == IDX_A);
    assign dat_acc    = (io_wr || io_rd) && (io_addr == DAT_A);
    assign idx_off    = idx_q - REG_BASE;
    assign idx_hit    = idx_off < 8'(NUM_REGS);
    assign dat_wr_hit = (state_q == IDX_ARMED) && io_wr && (io_addr == DAT_A) && idx_hit;
    assign armed      = (state_q == IDX_ARMED);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IDX_IDLE: begin
                if (idx_wr) state_d = IDX_ARMED;
            end
            IDX_ARMED: begin
                if (idx_wr)       state_d = IDX_ARMED;
                else if (dat_acc) state_d = IDX_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IDX_IDLE;
            idx_q   <= 8'h00;
        end else begin
            state_q <= state_d;
            if (idx_wr) idx_q <= io_wdata;
        end
    end

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[i] <= reg_reset(i);
            else if (dat_wr_hit && idx_off == 8'(i))
                regs_q[i] <= io_wdata;
        end
    end

    always_comb begin
        io_rdata = 8'hFF;
        if (state_q == IDX_ARMED && idx_hit) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (idx_off == 8'(i)) io_rdata = regs_q[i];
            end
        end
    end

    always_comb begin
        cfg.c_seg  = regs_q[R_CSEG][3:0];
        cfg.c_ro   = regs_q[R_CSEG][4];
        cfg.c_copy = regs_q[R_CSEG][5];
        cfg.d_seg  = regs_q[R_DSEG][3:0];
        cfg.d_ro   = regs_q[R_DSEG][4];
        cfg.d_all  = regs_q[R_DSEG][5];
        cfg.e_seg  = regs_q[R_ESEG][3:0];
        cfg.e_ro   = regs_q[R_ESEG][4];
        cfg.e_all  = regs_q[R_ESEG][5];
        cfg.f_ro   = regs_q[R_FCTL][0];
        cfg.f_copy = regs_q[R_FCTL][1];
        cfg.l2     = {regs_q[R_L2HI][3:0], regs_q[R_L2LO]};
        cfg.l1     = regs_q[R_L1][2:0];
    end

endmodule

// File: rtl/umem_window_decode.sv
module umem_window_decode
    import umem_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0] mem_addr,
    output logic              in_win,
    output rng_e              rng,
    output logic [1:0]        seg,
    output logic [3:0]        l2_idx
);

    localparam int HI_W = ADDR_W - 18;

    assign in_win = (mem_addr[ADDR_W-1:18] == HI_W'(3));
    assign rng    = rng_e'(mem_addr[17:16]);
    assign seg    = mem_addr[15:14];
    assign l2_idx = mem_addr[17:14];

endmodule

// File: rtl/umem_route.sv
module umem_route
    import umem_pkg::*;
(
    input  shadow_cfg_t cfg,
    input  logic        in_win,
    input  rng_e        rng,
    input  logic [1:0]  seg,
    input  logic [3:0]  l2_idx,
    input  logic        mem_rd,
    input  logic        mem_wr,
    output route_t      route
);

    logic [3:0] seg_en;
    logic       all_en;
    logic       ro;
    logic       copy;
    logic       l1_bit;
    logic       shadowed;

    always_comb begin
        seg_en = 4'h0;
        all_en = 1'b1;
        ro     = 1'b0;
        copy   = 1'b0;
        l1_bit = 1'b0;
        unique case (rng)
            RNG_C: begin
                seg_en = cfg.c_seg; ro = cfg.c_ro; copy = cfg.c_copy; l1_bit = cfg.l1[0];
            end
            RNG_D: begin
                seg_en = cfg.d_seg; all_en = cfg.d_all; ro = cfg.d_ro; l1_bit = cfg.l1[1];
            end
            RNG_E: begin
                seg_en = cfg.e_seg; all_en = cfg.e_all; ro = cfg.e_ro; l1_bit = cfg.l1[2];
            end
            RNG_F: begin
                seg_en = 4'hF; ro = cfg.f_ro; copy = cfg.f_copy; l1_bit = 1'b1;
            end
        endcase
        shadowed = seg_en[seg] && all_en;
    end

    always_comb begin
        route = '0;
        if (mem_rd || mem_wr) begin
            if (!in_win) begin
                route.sel_dram = 1'b1;
                route.l1       = 1'b1;
                route.l2       = 1'b1;
            end else if (!shadowed) begin
                route.sel_at = 1'b1;
            end else if (copy) begin
                route.sel_dram = mem_wr;
                route.sel_at   = !mem_wr;
            end else begin
                route.sel_dram = 1'b1;
                route.wr_inh   = mem_wr && ro;
                route.l1       = l1_bit;
                route.l2       = (rng == RNG_F) ? 1'b1 : cfg.l2[l2_idx];
            end
        end
    end

endmodule

// File: rtl/umem_shadow_decoder.sv
module umem_shadow_decoder
    import umem_pkg::*;
#(
    parameter int          ADDR_W   = 24,
    parameter int          IO_W     = 16,
    parameter logic [15:0] IDX_PORT = 16'h0022,
    parameter logic [15:0] DAT_PORT = 16'h0024,
    parameter logic [7:0]  REG_BASE = 8'h30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IO_W-1:0]   io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rd,
    input  logic              mem_wr,
    output logic              sel_at,
    output logic              sel_dram,
    output logic              wr_inhibit,
    output logic              cache_l1,
    output logic              cache_l2
);

    shadow_cfg_t cfg;
    logic        idx_armed;
    logic        in_win;
    rng_e        rng;
    logic [1:0]  seg;
    logic [3:0]  l2_idx;
    route_t      route;

    umem_cfg_regs #(
        .IO_W(IO_W), .IDX_PORT(IDX_PORT), .DAT_PORT(DAT_PORT), .REG_BASE(REG_BASE)
    ) i_cfg (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg(cfg), .armed(idx_armed)
    );

    umem_window_decode #(.ADDR_W(ADDR_W)) i_win (
        .mem_addr(mem_addr), .in_win(in_win), .rng(rng), .seg(seg), .l2_idx(l2_idx)
    );

    umem_route i_route (
        .cfg(cfg), .in_win(in_win), .rng(rng), .seg(seg), .l2_idx(l2_idx),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .route(route)
    );

    assign sel_at     = route.sel_at;
    assign sel_dram   = route.sel_dram;
    assign wr_inhibit = route.wr_inh;
    assign cache_l1   = route.l1;
    assign cache_l2   = route.l2;

endmodule

// File: rtl/umem_shadow_checker.sv
module umem_shadow_checker #(
    parameter int          ADDR_W   = 24,
    parameter int          IO_W     = 16,
    parameter logic [15:0] DAT_PORT = 16'h0024
) (
    input logic              clk,
    input logic              rst_n,
    input logic [IO_W-1:0]   io_addr,
    input logic              io_wr,
    input logic              io_rd,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              sel_at,
    input logic              sel_dram,
    input logic              wr_inhibit,
    input logic              cache_l1,
    input logic              cache_l2,
    input logic              idx_armed
);

    logic outside;
    logic data_hit;
    assign outside  = (mem_addr[ADDR_W-1:18] != (ADDR_W-18)'(3));
    assign data_hit = (io_wr || io_rd) && (io_addr == IO_W'(DAT_PORT)) && !io_wr ||
                      (io_rd && (io_addr == IO_W'(DAT_PORT)));

    p_sel_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_at && sel_dram));

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd || mem_wr) |-> !(sel_at || sel_dram || wr_inhibit || cache_l1 || cache_l2));

    p_strobe_selects_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> (sel_at || sel_dram));

    p_inhibit_on_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_inhibit |-> (mem_wr && sel_dram));

    p_at_uncached_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sel_at |-> !(cache_l1 || cache_l2 || wr_inhibit));

    p_outside_dram_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd || mem_wr) && outside) |-> (sel_dram && cache_l1 && cache_l2 && !wr_inhibit));

    p_data_read_disarms_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_armed && data_hit) |=> !idx_armed);

endmodule

bind umem_shadow_decoder umem_shadow_checker #(
    .ADDR_W(ADDR_W), .IO_W(IO_W), .DAT_PORT(DAT_PORT)
) i_checker (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .sel_at(sel_at),
    .sel_dram(sel_dram), .wr_inhibit(wr_inhibit), .cache_l1(cache_l1),
    .cache_l2(cache_l2), .idx_armed(idx_armed)
);

// File: tb/test_umem_shadow_decoder.sv
module test_umem_shadow_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 24;
    localparam logic [15:0] IDX = 16'h0022;
    localparam logic [15:0] DAT = 16'h0024;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       io_addr = '0;
    logic              io_wr = 1'b0;
    logic              io_rd = 1'b0;
    logic [7:0]        io_wdata = '0;
    logic [7:0]        io_rdata;
    logic [ADDR_W-1:0] mem_addr = '0;
    logic              mem_rd = 1'b0;
    logic              mem_wr = 1'b0;
    logic              sel_at, sel_dram, wr_inhibit, cache_l1, cache_l2;

    int errors = 0;
    int checks = 0;
    logic [7:0] mdl [7];
    logic [31:0] lfsr = 32'h1234_5679;

    always #(CLK_PERIOD/2) clk = ~clk;

    umem_shadow_decoder i_umem_shadow_decoder (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .sel_at(sel_at), .sel_dram(sel_dram),
        .wr_inhibit(wr_inhibit), .cache_l1(cache_l1), .cache_l2(cache_l2)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [15:0] p, input logic [7:0] d);
        @(negedge clk);
        io_addr = p; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] p, output logic [7:0] v);
        @(negedge clk);
        io_addr = p; io_rd = 1'b1;
        #1 v = io_rdata;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic set_reg(input int i, input logic [7:0] v);
        io_write(IDX, 8'h30 + 8'(i));
        io_write(DAT, v);
        mdl[i] = v;
    endtask

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    // {sel_at, sel_dram, wr_inhibit, l1, l2}, with a tag naming the requirement
    function automatic logic [4:0] model(input logic [ADDR_W-1:0] a, input logic rd,
                                         input logic wr, output string tag);
        logic [1:0] r = a[17:16];
        logic [1:0] s = a[15:14];
        logic [7:0] b;
        logic sh, ro, cp, l1;
        logic [11:0] l2v = {mdl[5][3:0], mdl[4]};
        tag = "R12";
        if (!(rd || wr)) return 5'b0;
        if (a[ADDR_W-1:18] != 6'd3) begin tag = "R4"; return 5'b01011; end
        if (r == 2'd3) begin
            if (mdl[3][1]) begin tag = "R9"; return wr ? 5'b01000 : 5'b10000; end
            tag = "R8";
            return {2'b01, wr && mdl[3][0], 2'b11};
        end
        b  = mdl[r];
        sh = b[s] && (r == 2'd0 ? 1'b1 : b[5]);
        ro = b[4];
        cp = (r == 2'd0) && b[5];
        l1 = mdl[6][r];
        if (!sh) begin tag = "R6"; return 5'b10000; end
        if (cp)  begin tag = "R10"; return wr ? 5'b01000 : 5'b10000; end
        tag = (wr && ro) ? "R7" : (wr ? "R5" : "R11");
        return {2'b01, wr && ro, l1, l2v[a[17:14]]};
    endfunction

    task automatic mem_check(input logic [ADDR_W-1:0] a, input logic rd, input logic wr);
        string tag;
        logic [4:0] exp;
        exp = model(a, rd, wr, tag);
        @(negedge clk);
        mem_addr = a; mem_rd = rd; mem_wr = wr;
        #1 check(tag, {3'b0, sel_at, sel_dram, wr_inhibit, cache_l1, cache_l2}, {3'b0, exp});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] v;
        for (int i = 0; i < 7; i++) mdl[i] = (i == 1 || i == 2) ? 8'h20 : 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R3: reset values
        for (int i = 0; i < 7; i++) begin
            io_write(IDX, 8'h30 + 8'(i));
            io_read(DAT, v);
            check("R3", v, mdl[i]);
        end
        // R1: data access disarms; R2: idle read returns FFh
        io_read(DAT, v);
        check("R1", v, 8'hFF);
        io_write(DAT, 8'h55);
        io_write(IDX, 8'h30);
        io_read(DAT, v);
        check("R2", v, 8'h00);
        // R1: write then readback through the pair
        set_reg(0, 8'h0F);
        io_write(IDX, 8'h30);
        io_read(DAT, v);
        check("R1", v, 8'h0F);
        // R2: unmapped index, write ignored and read FFh
        io_write(IDX, 8'h37);
        io_write(DAT, 8'hAA);
        io_write(IDX, 8'h37);
        io_read(DAT, v);
        check("R2", v, 8'hFF);
        io_write(IDX, 8'h2F);
        io_read(DAT, v);
        check("R2", v, 8'hFF);
        for (int i = 0; i < 7; i++) begin
            io_write(IDX, 8'h30 + 8'(i));
            io_read(DAT, v);
            check("R2", v, mdl[i]);
        end

        // Sweeps under many register images
        for (int k = 0; k < 48; k++) begin
            for (int i = 0; i < 7; i++) begin
                lfsr = next_rand(lfsr);
                v = lfsr[7:0];
                if (k < 4) v = (k[0]) ? 8'hFF : 8'h00;
                set_reg(i, v);
            end
            io_write(IDX, 8'h30 + 8'(k % 7));
            io_read(DAT, v);
            check("R1", v, mdl[k % 7]);
            for (int n = 0; n < 16; n++) begin
                logic [ADDR_W-1:0] a;
                a = 24'h0C0000 + ADDR_W'(n) * 24'h4000 + ADDR_W'((n * 24'h135 + k) & 24'h3FFF);
                mem_check(a, 1'b1, 1'b0);
                mem_check(a, 1'b0, 1'b1);
                mem_check(a, 1'b1, 1'b1);
                mem_check(a, 1'b0, 1'b0);
            end
            mem_check(24'h0BFFFF, 1'b1, 1'b0);
            mem_check(24'h0BFFFF, 1'b0, 1'b1);
            mem_check(24'h100000, 1'b0, 1'b1);
            mem_check(24'hFC0000, 1'b1, 1'b0);
            mem_check(24'h0C0000, 1'b0, 1'b1);
            mem_check(24'h0FFFFF, 1'b1, 1'b0);
        end

        @(negedge clk);
        mem_rd = 1'b0; mem_wr = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule